// File: doc/BRIEF.md
# Prescaled Reference Compare Timer

A 16-bit up-counter run from the system clock. The clock first passes through an optional divide-by-16 stage and then through an 8-bit programmable prescaler. Software reaches the timer through a small byte-addressed register port. The port holds a control word, a compare value, a spare capture word, the live count and a two-bit event register.

The counter climbs from zero toward the compare value. In the cycle where the counter reaches that value, a sticky reference flag is set. On the next advance the counter goes back to zero. The interrupt line is a level signal: it is high while the interrupt enable is set and the reference flag is pending. Software clears a flag by writing a one to its bit.

Typical use:
1. Load the compare value.
2. Clear any old flags.
3. Write the control word with the enable bit set.
4. Service the interrupt.
5. Acknowledge the interrupt through the event register.

Top module: `prct_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Control bit 0 enables the timer. While bit 0 is 0 the count holds its value. A control write that takes bit 0 from 1 to 0 sets both the control word and the compare value to zero.
- R3: Control bits 2:1 select the count clock: 1 gives every system cycle, 2 gives one cycle in 16, and 0 or 3 leave the counter stopped.
- R4: With prescale value P in control bits 15:8, the count advances once every (P+1)·D cycles, where D is 1 or 16. The first advance lands (P+1)·D cycles after the control or compare write, because either write restarts the prescaler phase.
- R5: The count runs 0,1,…,C and then back to 0, where C is the compare value (a compare value of 0 acts as 1). Event bit 1 is set on the same clock edge at which the count becomes C.
- R6: `irq` equals control bit 4 AND event bit 1, and follows both without delay.
- R7: Writing the event register clears each bit written as 1 and leaves each bit written as 0. A reference match in the same cycle as a clear wins, so the flag stays set.
- R8: Byte offsets are 0x00 control, 0x04 compare, 0x08 capture, 0x0C count and 0x11 events. The capture word is plain read/write storage. Reads from any other offset return 0.
- R9: A write to offset 0x0C loads the count. This load takes priority over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high (with bus_sel) |
| bus_addr | input | 5 | Byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that each register write lasts exactly one cycle and that no two registers are written in the same cycle. Two assertions also rely on the prescale field changing only through a control write, which restarts the prescaler. The bench holds to this by driving the bus from a single task: the task raises bus_sel for one clock, away from the active edge, and never overlaps two accesses. Clears that must land on a match edge are aligned by counting cycles from the preceding control write, so the collision is set up on purpose and not by chance.

// File: rtl/prct_pkg.sv
`timescale 1ns/1ps
package prct_pkg;
  typedef enum logic [1:0] {
    CLK_NONE0 = 2'd0,
    CLK_SYS   = 2'd1,
    CLK_SLOW  = 2'd2,
    CLK_NONE3 = 2'd3
  } clk_sel_e;

  localparam int MB_EN     = 0;
  localparam int MB_SEL_LO = 1;
  localparam int MB_IRQ_EN = 4;
  localparam int MB_PRE_LO = 8;

  localparam int EB_REF = 1;

  localparam logic [7:0] OFS_MODE = 8'h00;
  localparam logic [7:0] OFS_CMP  = 8'h04;
  localparam logic [7:0] OFS_CAPT = 8'h08;
  localparam logic [7:0] OFS_CNT  = 8'h0C;
  localparam logic [7:0] OFS_EVT  = 8'h11;

  function automatic logic sel_is_running(input logic [1:0] s);
    return (clk_sel_e'(s) == CLK_SYS) || (clk_sel_e'(s) == CLK_SLOW);
  endfunction

  function automatic logic sel_is_slow(input logic [1:0] s);
    return clk_sel_e'(s) == CLK_SLOW;
  endfunction
endpackage

// File: rtl/prct_prescaler.sv
`timescale 1ns/1ps
module prct_prescaler #(
  parameter int PRE_W    = 8,
  parameter int SLOW_DIV = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             slow,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre_val,
  output logic             base_tick,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;

  generate
    if (SLOW_DIV > 1) begin : g_div
      localparam int DIV_W = $clog2(SLOW_DIV);
      localparam logic [DIV_W-1:0] DIV_MAX = DIV_W'(SLOW_DIV - 1);
      logic [DIV_W-1:0] div_q;

      always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) div_q <= '0;
        else if (slow) div_q <= (div_q == DIV_MAX) ? '0 : div_q + DIV_W'(1);
      end

      assign base_tick = run && (!slow || (div_q == DIV_MAX));

      // R3: the slow clock never produces two back-to-back base ticks
      p_slow_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && slow && base_tick) |=> !base_tick);
    end else begin : g_nodiv
      assign base_tick = run;
    end
  endgenerate

  assign tick = base_tick && (pre_q == pre_val);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || restart) pre_q <= '0;
    else if (base_tick) pre_q <= (pre_q == pre_val) ? '0 : pre_q + PRE_W'(1);
  end

  // R4: after a restart only an undivided, unscaled clock may tick at once
  p_restart_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (tick == (run && !slow && (pre_val == '0))));
endmodule

// File: rtl/prct_counter.sv
`timescale 1ns/1ps
module prct_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] ref_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ref_match
);
  function automatic logic [CNT_W-1:0] eff_limit(input logic [CNT_W-1:0] r);
    return (r == '0) ? CNT_W'(1) : r;
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] lim);
    return (c == lim) ? '0 : c + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] nxt;

  assign lim       = eff_limit(ref_val);
  assign nxt       = next_count(cnt_q, lim);
  assign ref_match = tick && !load && (nxt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (tick) cnt_q <= nxt;
  end

  // R2: without an advance or a load the count holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));
  // R5: the count returns to zero after standing at the limit
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && (cnt_q == lim)) |=> (cnt_q == '0));
  // R9: a load wins over an advance
  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/prct_regs.sv
`timescale 1ns/1ps
module prct_regs
  import prct_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int PRE_W  = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [BUS_W-1:0]  cnt_q,
  input  logic              ref_match,
  output logic              run,
  output logic              slow,
  output logic [PRE_W-1:0]  pre_val,
  output logic              irq_en,
  output logic [BUS_W-1:0]  ref_q,
  output logic              evt_ref,
  output logic              cnt_load,
  output logic              restart
);
  localparam int EVT_W = 2;
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(OFS_CMP);
  localparam logic [ADDR_W-1:0] A_CAPT = ADDR_W'(OFS_CAPT);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);
  localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(OFS_EVT);

  logic [BUS_W-1:0] mode_q;
  logic [BUS_W-1:0] capt_q;
  logic [EVT_W-1:0] evt_q;
  logic [EVT_W-1:0] evt_clr;
  logic [EVT_W-1:0] evt_set;
  logic wr_any, wr_mode, wr_cmp, wr_capt, wr_evt;
  logic disabling;

  assign wr_any  = bus_sel && bus_wr;
  assign wr_mode = wr_any && (bus_addr == A_MODE);
  assign wr_cmp  = wr_any && (bus_addr == A_CMP);
  assign wr_capt = wr_any && (bus_addr == A_CAPT);
  assign wr_evt  = wr_any && (bus_addr == A_EVT);
  assign cnt_load = wr_any && (bus_addr == A_CNT);
  assign restart  = wr_mode || wr_cmp;
  assign disabling = wr_mode && mode_q[MB_EN] && !bus_wdata[MB_EN];

  assign run     = mode_q[MB_EN] && sel_is_running(mode_q[MB_SEL_LO +: 2]);
  assign slow    = sel_is_slow(mode_q[MB_SEL_LO +: 2]);
  assign pre_val = mode_q[MB_PRE_LO +: PRE_W];
  assign irq_en  = mode_q[MB_IRQ_EN];
  assign evt_ref = evt_q[EB_REF];

  assign evt_clr = wr_evt ? bus_wdata[EVT_W-1:0] : '0;
  always_comb begin
    evt_set = '0;
    evt_set[EB_REF] = ref_match;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      ref_q  <= '0;
      capt_q <= '0;
      evt_q  <= '0;
    end else begin
      if (disabling) begin
        mode_q <= '0;
        ref_q  <= '0;
      end else begin
        if (wr_mode) mode_q <= bus_wdata;
        if (wr_cmp)  ref_q  <= bus_wdata;
      end
      if (wr_capt) capt_q <= bus_wdata;
      evt_q <= (evt_q & ~evt_clr) | evt_set;
    end
  end

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = mode_q;
      A_CMP:   bus_rdata = ref_q;
      A_CAPT:  bus_rdata = capt_q;
      A_CNT:   bus_rdata = cnt_q;
      A_EVT:   bus_rdata = {{(BUS_W-EVT_W){1'b0}}, evt_q};
      default: bus_rdata = '0;
    endcase
  end

  // R2: switching the enable off wipes control and compare
  p_disable_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    disabling |=> ((mode_q == '0) && (ref_q == '0)));
  // R5: a match leaves the reference flag set
  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_match |=> evt_q[EB_REF]);
  // R7: a one clears the flag unless a match arrives at the same edge
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && bus_wdata[EB_REF] && !ref_match) |=> !evt_q[EB_REF]);
  // R7: a zero leaves a set flag alone
  p_w0_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !bus_wdata[EB_REF] && evt_q[EB_REF]) |=> evt_q[EB_REF]);
endmodule

// File: rtl/prct_timer.sv
`timescale 1ns/1ps
module prct_timer #(
  parameter int CNT_W    = 16,
  parameter int PRE_W    = 8,
  parameter int SLOW_DIV = 16,
  parameter int ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam int BUS_W = CNT_W;

  logic             run, slow, irq_en, evt_ref;
  logic             cnt_load, restart, base_tick, tick, ref_match;
  logic [PRE_W-1:0] pre_val;
  logic [BUS_W-1:0] ref_q;
  logic [CNT_W-1:0] cnt_q;

  prct_regs #(.BUS_W(BUS_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_q(cnt_q), .ref_match(ref_match), .run(run), .slow(slow),
    .pre_val(pre_val), .irq_en(irq_en), .ref_q(ref_q), .evt_ref(evt_ref),
    .cnt_load(cnt_load), .restart(restart)
  );

  prct_prescaler #(.PRE_W(PRE_W), .SLOW_DIV(SLOW_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .slow(slow), .restart(restart),
    .pre_val(pre_val), .base_tick(base_tick), .tick(tick)
  );

  prct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_load),
    .load_val(bus_wdata), .ref_val(ref_q), .cnt_q(cnt_q),
    .ref_match(ref_match)
  );

  assign irq = irq_en && evt_ref;

  // R6: the request drops as soon as the flag is cleared
  p_irq_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(evt_ref) |-> !irq);
  // R3: advances only come from a base tick of a running clock
  p_tick_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (base_tick && run));
endmodule

// File: tb/prct_timer_bench.sv
`timescale 1ns/1ps
module prct_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [15:0] rv;

  prct_timer u_prct_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual %0d cycles, expected fewer than 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  typedef struct packed {
    logic [7:0]  pre;
    logic [1:0]  sel;
    logic [15:0] cmp;
    logic [15:0] wait_c;
    logic [15:0] exp_cnt;
    logic        exp_flag;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'd0, 2'd1, 16'd10,  16'd5,  16'd5, 1'b0},
    '{8'd0, 2'd1, 16'd4,   16'd7,  16'd2, 1'b1},
    '{8'd2, 2'd1, 16'd100, 16'd9,  16'd3, 1'b0},
    '{8'd0, 2'd2, 16'd50,  16'd48, 16'd3, 1'b0},
    '{8'd1, 2'd2, 16'd2,   16'd96, 16'd0, 1'b1},
    '{8'd0, 2'd0, 16'd5,   16'd20, 16'd0, 1'b0},
    '{8'd0, 2'd3, 16'd5,   16'd20, 16'd0, 1'b0},
    '{8'd3, 2'd1, 16'd0,   16'd12, 16'd1, 1'b1},
    '{8'd0, 2'd1, 16'd3,   16'd3,  16'd3, 1'b1},
    '{8'd0, 2'd1, 16'd3,   16'd2,  16'd2, 1'b0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [15:0] mode_word(input logic [7:0] p, input logic ie,
                                            input logic [1:0] s, input logic en);
    return {p, 3'b000, ie, 1'b1, s, en};
  endfunction

  task automatic arm(input logic [7:0] p, input logic ie, input logic [1:0] s,
                     input logic [15:0] c);
    wr(5'h00, 16'h0000);
    wr(5'h0C, 16'h0000);
    wr(5'h11, 16'h0003);
    wr(5'h04, c);
    wr(5'h00, mode_word(p, ie, s, 1'b1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(5'h00, rv); check("R1 control", rv, 16'h0);
    rd(5'h04, rv); check("R1 compare", rv, 16'h0);
    rd(5'h0C, rv); check("R1 count", rv, 16'h0);
    rd(5'h11, rv); check("R1 events", rv, 16'h0);
    check("R1 irq", {15'd0, irq}, 16'h0);

    // R3 R4 R5 R6: table of clock and compare configurations
    for (int i = 0; i < NV; i++) begin
      arm(VECS[i].pre, 1'b1, VECS[i].sel, VECS[i].cmp);
      repeat (int'(VECS[i].wait_c)) @(negedge clk);
      rd(5'h0C, rv); check($sformatf("R4 R5 vector %0d count", i), rv, VECS[i].exp_cnt);
      rd(5'h11, rv); check($sformatf("R5 vector %0d flag", i), rv, {14'd0, VECS[i].exp_flag, 1'b0});
      check($sformatf("R6 vector %0d irq", i), {15'd0, irq}, {15'd0, VECS[i].exp_flag});
    end

    // R8: capture storage and unmapped offsets
    wr(5'h08, 16'hBEEF);
    rd(5'h08, rv); check("R8 capture", rv, 16'hBEEF);
    rd(5'h02, rv); check("R8 offset 0x02", rv, 16'h0);
    rd(5'h10, rv); check("R8 offset 0x10", rv, 16'h0);
    rd(5'h14, rv); check("R8 offset 0x14", rv, 16'h0);

    // R2: disabling clears control and compare
    arm(8'd0, 1'b0, 2'd1, 16'h0055);
    wr(5'h00, 16'h0010);
    rd(5'h00, rv); check("R2 control cleared", rv, 16'h0);
    rd(5'h04, rv); check("R2 compare cleared", rv, 16'h0);

    // R2: enable bit low holds the count
    wr(5'h04, 16'd1000);
    wr(5'h0C, 16'd7);
    wr(5'h00, 16'h0002);
    repeat (10) @(negedge clk);
    rd(5'h00, rv); check("R2 control kept when not disabling", rv, 16'h0002);
    rd(5'h0C, rv); check("R2 count held", rv, 16'd7);

    // R9: load while running wins over an advance
    wr(5'h00, mode_word(8'd0, 1'b0, 2'd1, 1'b1));
    repeat (2) @(negedge clk);
    wr(5'h0C, 16'h0100);
    rd(5'h0C, rv); check("R9 load value", rv, 16'h0100);
    repeat (4) @(negedge clk);
    rd(5'h0C, rv); check("R9 count after load", rv, 16'h0104);

    // R6: flag without enable gives no irq, then enabling raises it
    arm(8'd0, 1'b0, 2'd1, 16'd3);
    repeat (3) @(negedge clk);
    rd(5'h11, rv); check("R6 flag set", rv, 16'h0002);
    check("R6 irq masked", {15'd0, irq}, 16'h0);
    wr(5'h00, mode_word(8'd0, 1'b1, 2'd1, 1'b1));
    check("R6 irq raised", {15'd0, irq}, 16'h1);

    // R7: zero keeps, one clears (timer stopped first)
    wr(5'h00, 16'h0000);
    check("R6 irq after disable", {15'd0, irq}, 16'h0);
    wr(5'h11, 16'h0000);
    rd(5'h11, rv); check("R7 write zero keeps", rv, 16'h0002);
    wr(5'h11, 16'h0002);
    rd(5'h11, rv); check("R7 write one clears", rv, 16'h0000);

    // R7: clear at the match edge loses to the match
    arm(8'd0, 1'b1, 2'd1, 16'd3);
    repeat (2) @(negedge clk);
    wr(5'h11, 16'h0003);
    rd(5'h11, rv); check("R7 set wins over clear", rv, 16'h0002);
    rd(5'h0C, rv); check("R5 count at match", rv, 16'd3);
    check("R6 irq at match", {15'd0, irq}, 16'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule